// File: doc/BRIEF.md
# Zero-Run Automute and Mute Combiner

This block sits beside the sample path of three stereo converters. It watches each converter's stereo frames and counts unbroken runs of midrail (all-zero) frames. When a converter has seen a long enough run, the block raises that converter's zero flag. The flag drops on the first frame that carries any nonzero bit.

The zero flags are combined with several mute sources to give one soft-mute request per converter:

- a direct mute bit per converter;
- a global mute bit;
- a shared mute pin.

The mute pin works in one of two directions:

- **Output:** the block drives the pin high when the converters chosen by a 2-bit selector are all idle.
- **Input:** a high level on the pin mutes the selected converters, and a low level vetoes automute entirely.

In both directions the pin level feeds back into the combiner. So a pin driven high by the block also mutes the converters it represents. An enable bit gates the whole pin-derived term, and the direct and global mutes are never affected by it.

Top module: `zm_automute`

## Requirements
- R1: After reset every zero flag is low, the pin is not driven (`mpin_oe` low, `mpin_out` low) and, with all control inputs low, no soft-mute is requested.
- R2: A converter's zero flag rises on the clock edge that accepts its (ZERO_RUN+1)th consecutive frame whose left and right samples are both zero. With the default ZERO_RUN of 1024 that is frame 1025, and after 1024 such frames the flag is still low.
- R3: A frame in which either channel of a converter is nonzero clears that converter's run count and its zero flag on the edge that accepts the frame.
- R4: Cycles with `smp_vld` low neither count toward nor break a zero run, and they leave every zero flag unchanged.
- R5: `pin_sel` chooses the converters tied to the pin:
  - 2'b00 selects all three;
  - 2'b01 selects converter 0 (bit 0 of the per-converter buses);
  - 2'b10 selects converter 1;
  - 2'b11 selects converter 2.
- R6: With `pin_out_en` high, `mpin_oe` is high and `mpin_out` is high exactly when every selected zero flag is high. With `pin_out_en` low, `mpin_oe` and `mpin_out` are both low.
- R7: With `pin_out_en` low, `amute_en` high and `mpin_in` high, every selected converter has its soft-mute bit high.
- R8: With `pin_out_en` low and `mpin_in` low, no soft-mute results from zero flags. The soft-mute bits equal `ch_mute` ORed with `all_mute` on every bit.
- R9: `all_mute` high sets every soft-mute bit, whatever the other inputs are.
- R10: `ch_mute[i]` high sets `soft_mute[i]`.
- R11: With `pin_out_en` high and `amute_en` high, a pin driven high by the block sets the soft-mute bit of every selected converter. Unselected converters keep only their direct and global mutes.
- R12: With `amute_en` low, the pin level has no effect on `soft_mute`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Frame strobe; one stereo frame per converter per strobe |
| smp_l | input | NDAC*SMP_W | Left samples, converter i at bits [i*SMP_W +: SMP_W] |
| smp_r | input | NDAC*SMP_W | Right samples, same packing as smp_l |
| ch_mute | input | NDAC | Direct mute per converter |
| all_mute | input | 1 | Global mute |
| amute_en | input | 1 | Enables the pin-derived mute term |
| pin_out_en | input | 1 | 1: the block drives the mute pin; 0: the pin is an input |
| pin_sel | input | 2 | Selects which converters the pin represents |
| mpin_in | input | 1 | Level seen on the mute pin when it is an input |
| mpin_out | output | 1 | Value the block drives onto the mute pin |
| mpin_oe | output | 1 | Output enable for the mute pin |
| zflag | output | NDAC | Zero-run flag per converter |
| soft_mute | output | NDAC | Soft-mute request per converter |

## Verification
Directed frames probe the run threshold:
- Exactly ZERO_RUN all-zero frames, then one more, separate a counter that is off by one in either direction.
- A single nonzero bit in one channel of one converter shows that a lone channel breaks the run and that the clear lands on the same frame.
- Idle cycles carrying nonzero data show that unqualified data is ignored.

With the flags left in a mixed state, each selector code is tried in both pin directions, with the pin held high and low and with automute on and off. This tells the selector mapping, the pin feedback and the automute veto apart from the direct and global mutes.

A seeded random phase then mixes mostly-zero frames, random strobes and random control settings, checked every cycle against a bench model.

// File: rtl/zm_pkg.sv
package zm_pkg;
   // Largest converter count the 2-bit selector can address.
   localparam int unsigned MAX_DAC = 3;
   localparam int unsigned SEL_W   = 2;
   // Selector code that ties the pin to every converter.
   localparam logic [SEL_W-1:0] SEL_ALL = 2'b00;
   typedef logic [SEL_W-1:0] pin_sel_t;
endpackage

// File: rtl/zm_zero_det.sv
// Per-converter run counter: raises the flag on the frame after ZERO_RUN
// consecutive all-zero frames, clears on any nonzero frame.
module zm_zero_det #(
   parameter int unsigned SMP_W    = 24,
   parameter int unsigned ZERO_RUN = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld,
   input  logic [SMP_W-1:0] left,
   input  logic [SMP_W-1:0] right,
   output logic             flag
);
   localparam int unsigned CNT_W = $clog2(ZERO_RUN + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ZERO_RUN);

   generate
      if (ZERO_RUN < 1) begin : g_bad_run
         $error("zm_zero_det: ZERO_RUN must be at least 1");
      end
      if (SMP_W < 1) begin : g_bad_width
         $error("zm_zero_det: SMP_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] run_cnt;
   logic             frame_zero;

   assign frame_zero = (left == '0) && (right == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt <= '0;
         flag    <= 1'b0;
      end else if (vld) begin
         if (frame_zero) begin
            if (run_cnt == CNT_TOP) flag <= 1'b1;
            else                    run_cnt <= run_cnt + 1'b1;
         end else begin
            run_cnt <= '0;
            flag    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/zm_pin_map.sv
// Decodes the selector, forms the pin drive value and the effective pin level.
module zm_pin_map
   import zm_pkg::*;
#(
   parameter int unsigned NDAC = 3
) (
   input  logic [NDAC-1:0] flags,
   input  pin_sel_t        sel,
   input  logic            out_en,
   input  logic            pin_in,
   output logic [NDAC-1:0] mask,
   output logic            pin_drive,
   output logic            pin_lvl
);
   generate
      if (NDAC < 1 || NDAC > MAX_DAC) begin : g_bad_ndac
         $error("zm_pin_map: NDAC must lie between 1 and MAX_DAC");
      end
      for (genvar i = 0; i < NDAC; i++) begin : g_mask
         assign mask[i] = (sel == SEL_ALL) || (sel == SEL_W'(i + 1));
      end
   endgenerate

   logic sel_idle;
   assign sel_idle  = (|mask) && ((flags & mask) == mask);
   assign pin_drive = out_en & sel_idle;
   assign pin_lvl   = out_en ? pin_drive : pin_in;
endmodule

// File: rtl/zm_mute_mix.sv
// Per-converter OR of the global, direct and gated pin-derived mutes.
module zm_mute_mix #(
   parameter int unsigned NDAC = 3
) (
   input  logic            all_mute,
   input  logic [NDAC-1:0] ch_mute,
   input  logic            amute_en,
   input  logic [NDAC-1:0] mask,
   input  logic            pin_lvl,
   output logic [NDAC-1:0] soft_mute
);
   logic pin_term;
   assign pin_term = amute_en & pin_lvl;

   generate
      for (genvar i = 0; i < NDAC; i++) begin : g_mix
         assign soft_mute[i] = all_mute | ch_mute[i] | (pin_term & mask[i]);
      end
   endgenerate
endmodule

// File: rtl/zm_automute.sv
module zm_automute
   import zm_pkg::*;
#(
   parameter int unsigned NDAC     = 3,
   parameter int unsigned SMP_W    = 24,
   parameter int unsigned ZERO_RUN = 1024
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  smp_vld,
   input  logic [NDAC*SMP_W-1:0] smp_l,
   input  logic [NDAC*SMP_W-1:0] smp_r,
   input  logic [NDAC-1:0]       ch_mute,
   input  logic                  all_mute,
   input  logic                  amute_en,
   input  logic                  pin_out_en,
   input  logic [1:0]            pin_sel,
   input  logic                  mpin_in,
   output logic                  mpin_out,
   output logic                  mpin_oe,
   output logic [NDAC-1:0]       zflag,
   output logic [NDAC-1:0]       soft_mute
);
   logic [NDAC-1:0] sel_mask;
   logic            pin_drive;
   logic            pin_lvl;

   generate
      for (genvar i = 0; i < NDAC; i++) begin : g_det
         zm_zero_det #(.SMP_W(SMP_W), .ZERO_RUN(ZERO_RUN)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .vld   (smp_vld),
            .left  (smp_l[i*SMP_W +: SMP_W]),
            .right (smp_r[i*SMP_W +: SMP_W]),
            .flag  (zflag[i])
         );
      end
   endgenerate

   zm_pin_map #(.NDAC(NDAC)) u_map (
      .flags     (zflag),
      .sel       (pin_sel),
      .out_en    (pin_out_en),
      .pin_in    (mpin_in),
      .mask      (sel_mask),
      .pin_drive (pin_drive),
      .pin_lvl   (pin_lvl)
   );

   zm_mute_mix #(.NDAC(NDAC)) u_mix (
      .all_mute  (all_mute),
      .ch_mute   (ch_mute),
      .amute_en  (amute_en),
      .mask      (sel_mask),
      .pin_lvl   (pin_lvl),
      .soft_mute (soft_mute)
   );

   assign mpin_out = pin_drive;
   assign mpin_oe  = pin_out_en;
endmodule

// File: rtl/zm_automute_chk.sv
module zm_automute_chk #(
   parameter int unsigned NDAC  = 3,
   parameter int unsigned SMP_W = 24
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  smp_vld,
   input logic [NDAC*SMP_W-1:0] smp_l,
   input logic [NDAC*SMP_W-1:0] smp_r,
   input logic [NDAC-1:0]       ch_mute,
   input logic                  all_mute,
   input logic                  amute_en,
   input logic                  pin_out_en,
   input logic                  mpin_in,
   input logic                  mpin_out,
   input logic                  mpin_oe,
   input logic [NDAC-1:0]       zflag,
   input logic [NDAC-1:0]       soft_mute
);
   generate
      for (genvar i = 0; i < NDAC; i++) begin : g_dac
         // R3: a nonzero frame clears the flag on its own edge
         p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_vld && ((smp_l[i*SMP_W +: SMP_W] != '0) || (smp_r[i*SMP_W +: SMP_W] != '0)))
            |=> !zflag[i]);
         // R2: a flag only rises on an accepted all-zero frame
         p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(zflag[i]) |-> $past(smp_vld && (smp_l[i*SMP_W +: SMP_W] == '0)
                                      && (smp_r[i*SMP_W +: SMP_W] == '0)));
      end
   endgenerate

   p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(zflag));

   p_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      all_mute |-> (&soft_mute));

   p_direct_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mute & ~soft_mute) == '0);

   p_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_out_en |-> (!mpin_out && !mpin_oe));

   p_veto_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_out_en && !mpin_in) |-> (soft_mute == (ch_mute | {NDAC{all_mute}})));

   p_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !amute_en |-> (soft_mute == (ch_mute | {NDAC{all_mute}})));
endmodule

bind zm_automute zm_automute_chk #(.NDAC(NDAC), .SMP_W(SMP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_vld    (smp_vld),
   .smp_l      (smp_l),
   .smp_r      (smp_r),
   .ch_mute    (ch_mute),
   .all_mute   (all_mute),
   .amute_en   (amute_en),
   .pin_out_en (pin_out_en),
   .mpin_in    (mpin_in),
   .mpin_out   (mpin_out),
   .mpin_oe    (mpin_oe),
   .zflag      (zflag),
   .soft_mute  (soft_mute)
);

// File: tb/sim_zm_automute.sv
module sim_zm_automute;
   localparam int NDAC  = 3;
   localparam int SMP_W = 24;
   localparam int RUN   = 1024;
   localparam int DW    = NDAC * SMP_W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            smp_vld = 1'b0;
   logic [DW-1:0]   smp_l = '0;
   logic [DW-1:0]   smp_r = '0;
   logic [NDAC-1:0] ch_mute = '0;
   logic            all_mute = 1'b0;
   logic            amute_en = 1'b0;
   logic            pin_out_en = 1'b0;
   logic [1:0]      pin_sel = 2'b00;
   logic            mpin_in = 1'b0;
   logic            mpin_out, mpin_oe;
   logic [NDAC-1:0] zflag, soft_mute;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;
   int  zcnt [NDAC];
   logic [NDAC-1:0] m_flag = '0;

   zm_automute #(.NDAC(NDAC), .SMP_W(SMP_W), .ZERO_RUN(RUN)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
      .ch_mute(ch_mute), .all_mute(all_mute), .amute_en(amute_en),
      .pin_out_en(pin_out_en), .pin_sel(pin_sel), .mpin_in(mpin_in),
      .mpin_out(mpin_out), .mpin_oe(mpin_oe), .zflag(zflag), .soft_mute(soft_mute)
   );

   always #10 clk = ~clk;

   function automatic logic [NDAC-1:0] e_mask(logic [1:0] s);
      return (s == 2'b00) ? 3'b111 : (3'b001 << (s - 2'd1));
   endfunction
   function automatic logic e_drive();
      logic [NDAC-1:0] m = e_mask(pin_sel);
      return pin_out_en && ((m_flag & m) == m);
   endfunction
   function automatic logic [NDAC-1:0] e_mute();
      logic lvl = pin_out_en ? e_drive() : mpin_in;
      return {NDAC{all_mute}} | ch_mute | ({NDAC{amute_en && lvl}} & e_mask(pin_sel));
   endfunction

   task automatic model_edge();
      if (!rst_n) begin
         for (int i = 0; i < NDAC; i++) zcnt[i] = 0;
         m_flag = '0;
      end else if (smp_vld) begin
         for (int i = 0; i < NDAC; i++) begin
            if (smp_l[i*SMP_W +: SMP_W] == '0 && smp_r[i*SMP_W +: SMP_W] == '0) begin
               if (zcnt[i] == RUN) m_flag[i] = 1'b1;
               else zcnt[i]++;
            end else begin
               zcnt[i] = 0;
               m_flag[i] = 1'b0;
            end
         end
      end
   endtask

   task automatic check(input string tag);
      logic [NDAC-1:0] em = e_mute();
      logic ed = e_drive();
      checks++;
      if (zflag !== m_flag || soft_mute !== em || mpin_out !== ed || mpin_oe !== pin_out_en) begin
         errors++;
         $display("FAIL %s: zflag=%b/%b soft_mute=%b/%b mpin_out=%b/%b mpin_oe=%b/%b (actual/expected)",
                  tag, zflag, m_flag, soft_mute, em, mpin_out, ed, mpin_oe, pin_out_en);
      end
   endtask

   task automatic step(input logic v, input logic [DW-1:0] l, input logic [DW-1:0] r,
                       input string tag);
      @(negedge clk);
      smp_vld = v; smp_l = l; smp_r = r;
      @(posedge clk);
      model_edge();
      #1;
      check(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      finish_run();
   end

   initial begin
      void'($urandom(32'd5417));
      step(1'b0, '0, '0, "R1 reset");
      step(1'b0, '0, '0, "R1 reset");
      @(negedge clk); rst_n = 1'b1;
      step(1'b0, '0, '0, "R1 reset state");

      // R2: ZERO_RUN zero frames leave flags low, one more raises them
      for (int k = 0; k < RUN; k++) step(1'b1, '0, '0, "R2 below threshold");
      step(1'b1, '0, '0, "R2 threshold frame");

      // R6/R11: output mode, all selected
      pin_out_en = 1'b1; amute_en = 1'b1; pin_sel = 2'b00;
      step(1'b1, '0, '0, "R6 R11 pin drives all");
      amute_en = 1'b0;
      step(1'b1, '0, '0, "R12 gate off");
      amute_en = 1'b1;

      // R3: one nonzero bit on converter 1 left channel
      step(1'b1, 72'h1 << SMP_W, '0, "R3 clear same frame");
      step(1'b1, '0, '0, "R3 run restarted");

      // R5: selector mapping with flags 101
      pin_sel = 2'b01; step(1'b1, '0, '0, "R5 sel dac0");
      pin_sel = 2'b10; step(1'b1, '0, '0, "R5 sel dac1");
      pin_sel = 2'b11; step(1'b1, '0, '0, "R5 sel dac2 R11");

      // R4: idle cycles with nonzero data
      for (int k = 0; k < 5; k++) step(1'b0, {DW{1'b1}}, {DW{1'b1}}, "R4 idle ignored");

      // R7: input mode, pin high
      pin_out_en = 1'b0; mpin_in = 1'b1;
      for (int s = 0; s < 4; s++) begin
         pin_sel = 2'(s); step(1'b0, '0, '0, "R7 pin in high");
      end

      // R8: input mode, pin low vetoes automute
      mpin_in = 1'b0; pin_sel = 2'b00;
      step(1'b0, '0, '0, "R8 veto");
      ch_mute = 3'b010; step(1'b0, '0, '0, "R8 R10 direct mute");
      ch_mute = 3'b000; all_mute = 1'b1;
      step(1'b0, '0, '0, "R9 global mute");
      pin_out_en = 1'b1; amute_en = 1'b0; step(1'b0, '0, '0, "R9 global out mode");
      all_mute = 1'b0;

      // Random mix
      for (int k = 0; k < 2000; k++) begin
         logic [DW-1:0] l = '0, r = '0;
         ch_mute    = 3'($urandom % 8);
         all_mute   = ($urandom % 8) == 0;
         amute_en   = $urandom % 2;
         pin_out_en = $urandom % 2;
         pin_sel    = 2'($urandom % 4);
         mpin_in    = $urandom % 2;
         for (int i = 0; i < NDAC; i++) begin
            if (($urandom % 16) == 0) l[i*SMP_W +: SMP_W] = SMP_W'($urandom);
            if (($urandom % 16) == 0) r[i*SMP_W +: SMP_W] = SMP_W'($urandom);
         end
         step(($urandom % 4) != 0, l, r, "R10 R5 R6 random");
      end

      finish_run();
   end
endmodule